// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block takes serial data from an outside source that supplies both the bit clock and the data line. It acts as the clock slave: it never drives the clock. Both lines pass through a synchroniser into the core clock domain. Each falling edge of the outside clock samples one data bit, least significant bit first. A word is 8 bits, or 9 bits when the wide mode is on. Each finished word goes into a two-entry receive FIFO. Software reads the oldest word through a data port, and a read strobe removes that word from the FIFO.

A flag shows that the FIFO holds data, and an interrupt request follows that flag through an enable. A word that finishes while the FIFO is full is dropped. The drop raises a sticky overrun flag and stops reception. Dropping the continuous-receive enable is the only way to clear it. The sampling path needs no core-side action to take in a word, so a word can arrive while the core sleeps. Its arrival raises a wake request, and reads are refused while the core is asleep.

The control state machine has three states:
- `RX_OFF`: the receiver is idle and the bit counter is held at zero.
- `RX_SHIFT`: bits are being collected.
- `RX_HALT`: an overrun has occurred and reception is blocked.

Its transitions are:
- `RX_OFF` goes to `RX_SHIFT` once the receiver is active.
- `RX_SHIFT` goes back to `RX_OFF` when any enable condition drops, which discards a partial word.
- `RX_SHIFT` goes to `RX_HALT` when a word finishes against a full FIFO.
- `RX_HALT` goes to `RX_OFF` only when `cont_rx_en` is low.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset, `rd_data`, `rd_bit9`, `rx_flag`, `irq`, `overrun` and `wake_req` are all 0.
- R2: Each falling edge of `ser_clk` samples one bit of `ser_data`, least significant bit first. After 8 bits (8-bit mode), the word appears on `rd_data` and `rx_flag` goes to 1.
- R3: When `nine_bit_en` is 1, a word is 9 bits. The ninth bit received is presented on `rd_bit9`, and the first eight bits are presented on `rd_data`. In 8-bit mode `rd_bit9` reads 0.
- R4: `irq` is 1 exactly when `rx_flag` is 1 and `int_en` is 1.
- R5: The FIFO holds two words and presents the oldest one. A one-cycle `rd_pop` removes that word. `rx_flag` drops when the FIFO is empty. A pop on an empty FIFO changes nothing, and an empty FIFO shows `rd_data` = 0.
- R6: A word that completes while the FIFO holds two words is discarded and sets `overrun`. Reception then stays blocked, even after the FIFO has been emptied.
- R7: `overrun` stays set while `cont_rx_en` is 1, whatever the other controls do. Clearing `cont_rx_en` clears it, and reception works again after re-enabling.
- R8: Reception runs only when `port_en`=1, `sync_mode`=1, `clk_src_master`=0 and `cont_rx_en`=1. Otherwise, edges on `ser_clk` store nothing.
- R9: `single_rx_en` and `addr_det_en` have no effect on reception. In particular, `single_rx_en`=1 does not receive when `cont_rx_en`=0.
- R10: While `core_sleep` is 1, words are still received, `rd_pop` is ignored, and `wake_req` is 1 whenever `irq` is 1. It is 0 otherwise.
- R11: Leaving the active condition in the middle of a word discards the bits already collected. The next word after re-enabling starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Externally supplied serial bit clock |
| ser_data | input | 1 | Serial data, sampled on the falling edge of `ser_clk` |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | Clock source select, must be 0 (external clock) |
| cont_rx_en | input | 1 | Continuous-receive enable; clearing it clears overrun |
| single_rx_en | input | 1 | Single-receive enable, ignored |
| nine_bit_en | input | 1 | 9-bit word mode |
| addr_det_en | input | 1 | Address-detect enable, ignored |
| int_en | input | 1 | Receive interrupt enable |
| core_sleep | input | 1 | Core is asleep; reads are refused |
| rd_pop | input | 1 | Read strobe that removes the oldest word |
| rd_data | output | 8 | Low bits of the oldest word |
| rd_bit9 | output | 1 | Ninth bit of the oldest word |
| rx_flag | output | 1 | FIFO holds at least one word |
| irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky overrun error |
| wake_req | output | 1 | Wake request during sleep |

## Verification
Bit patterns with alternating, edge-heavy and all-ones values (A5, 81, FF, 3C) tell a correct LSB-first order and correct falling-edge sampling apart from reversed or shifted assembly. 9-bit words with the top bit set and clear separate the ninth bit from the data byte. Two and then three back-to-back words tell the FIFO's ordering and its full boundary apart from the overrun path. Bursts sent with each enable term removed, and with the ignored controls set, show which controls gate reception. A word cut short and words received during sleep cover the partial-word discard and the wake request.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    typedef enum logic [1:0] {
        RX_OFF   = 2'd0,
        RX_SHIFT = 2'd1,
        RX_HALT  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/sync_rx_edge.sv
// Brings the outside clock and data into the core domain and flags falling edges.
module sync_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    output logic fall,
    output logic dat_s
);
    logic [STAGES:0]   ck_pipe;
    logic [STAGES-1:0] dt_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_pipe <= '0;
            dt_pipe <= '0;
        end else begin
            ck_pipe <= {ck_pipe[STAGES-1:0], ser_clk};
            dt_pipe <= {dt_pipe[STAGES-2:0], ser_data};
        end
    end

    // the data bit is aligned with the clock sample of the same age
    assign fall  = ck_pipe[STAGES] & ~ck_pipe[STAGES-1];
    assign dat_s = dt_pipe[STAGES-1];
endmodule

// File: rtl/sync_rx_fifo.sv
// Small receive queue; the oldest entry is always presented.
module sync_rx_fifo #(
    parameter int WORD_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [WORD_W-1:0] word_in,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              not_empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign not_empty = (count != '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign head      = not_empty ? mem[rd_ptr] : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (do_push && wr_ptr == PTR_W'(i))
                mem[i] <= word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/sync_rx_ctrl.sv
// Receive state machine and word assembly.
module sync_rx_ctrl
    import sync_rx_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              cont_en,
    input  logic              nine_bit,
    input  logic              fall,
    input  logic              dat,
    input  logic              fifo_full,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic              overrun
);
    localparam int CNT_W = $clog2(WORD_W);

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt, last;
    logic [WORD_W-1:0] bits;
    logic              done;

    assign last = nine_bit ? CNT_W'(WORD_W - 1) : CNT_W'(WORD_W - 2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_OFF;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt  = state;
        done = 1'b0;
        unique case (state)
            RX_OFF:   if (active) nxt = RX_SHIFT;
            RX_SHIFT: begin
                if (!active)
                    nxt = RX_OFF;
                else if (fall && cnt == last) begin
                    done = 1'b1;
                    if (fifo_full) nxt = RX_HALT;
                end
            end
            RX_HALT:  if (!cont_en) nxt = RX_OFF;
            default:  nxt = RX_OFF;
        endcase
    end

    // outputs
    always_comb begin
        push_word      = bits;
        push_word[cnt] = dat;
        if (!nine_bit) push_word[WORD_W-1] = 1'b0;
        push    = done && !fifo_full;
        overrun = (state == RX_HALT);
    end

    // bit counter and partial word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bits <= '0;
        end else if (state != RX_SHIFT || !active) begin
            cnt  <= '0;
            bits <= '0;
        end else if (fall) begin
            if (cnt == last) begin
                cnt  <= '0;
                bits <= '0;
            end else begin
                bits[cnt] <= dat;
                cnt       <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
    parameter int DATA_W      = 8,
    parameter int FIFO_DEPTH  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              cont_rx_en,
    input  logic              single_rx_en,
    input  logic              nine_bit_en,
    input  logic              addr_det_en,
    input  logic              int_en,
    input  logic              core_sleep,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bit9,
    output logic              rx_flag,
    output logic              irq,
    output logic              overrun,
    output logic              wake_req
);
    localparam int WORD_W = DATA_W + 1;

    logic              fall, dat_s, active, push, full, not_empty, pop;
    logic [WORD_W-1:0] push_word, head;
    logic              ignored_unused;

    // these two controls do not influence slave reception
    assign ignored_unused = single_rx_en | addr_det_en;

    assign active = port_en & sync_mode & ~clk_src_master & cont_rx_en;
    assign pop    = rd_pop & ~core_sleep;

    sync_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .fall(fall), .dat_s(dat_s)
    );

    sync_rx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active), .cont_en(cont_rx_en),
        .nine_bit(nine_bit_en), .fall(fall), .dat(dat_s), .fifo_full(full),
        .push(push), .push_word(push_word), .overrun(overrun)
    );

    sync_rx_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .word_in(push_word), .pop(pop),
        .head(head), .not_empty(not_empty), .full(full)
    );

    assign rd_data  = head[DATA_W-1:0];
    assign rd_bit9  = head[DATA_W];
    assign rx_flag  = not_empty;
    assign irq      = not_empty & int_en;
    assign wake_req = core_sleep & irq;
endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic cont_rx_en,
    input logic int_en,
    input logic core_sleep,
    input logic rd_pop,
    input logic rx_flag,
    input logic irq,
    input logic overrun,
    input logic wake_req
);
    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_flag && int_en));

    // R5
    flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_flag) |-> $past(rd_pop));

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && cont_rx_en) |=> overrun);

    // R7
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overrun) |-> !$past(cont_rx_en));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(cont_rx_en));

    // R10
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_flag) |-> !$past(core_sleep));

    // R10
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (core_sleep && rx_flag));
endmodule

bind sync_slave_rx sync_slave_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cont_rx_en(cont_rx_en), .int_en(int_en),
    .core_sleep(core_sleep), .rd_pop(rd_pop), .rx_flag(rx_flag), .irq(irq),
    .overrun(overrun), .wake_req(wake_req)
);

// File: tb/sync_slave_rx_test.sv
module sync_slave_rx_test;
    logic clk = 0, rst_n = 0;
    logic ser_clk = 1, ser_data = 0;
    logic port_en = 0, sync_mode = 0, clk_src_master = 0, cont_rx_en = 0;
    logic single_rx_en = 0, nine_bit_en = 0, addr_det_en = 0, int_en = 0;
    logic core_sleep = 0, rd_pop = 0;
    logic [7:0] rd_data;
    logic rd_bit9, rx_flag, irq, overrun, wake_req;

    int checks = 0, errors = 0;
    bit cmp_en = 0, done = 0;

    // behavioural model
    logic [8:0] q[$];
    bit m_halt = 0;
    int m_cnt = 0;
    logic [8:0] m_bits = '0;

    always #5 clk = ~clk;

    sync_slave_rx uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .port_en(port_en), .sync_mode(sync_mode), .clk_src_master(clk_src_master),
        .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en), .nine_bit_en(nine_bit_en),
        .addr_det_en(addr_det_en), .int_en(int_en), .core_sleep(core_sleep),
        .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9), .rx_flag(rx_flag),
        .irq(irq), .overrun(overrun), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_active();
        return port_en && sync_mode && !clk_src_master && cont_rx_en;
    endfunction

    function automatic logic [8:0] m_head();
        return (q.size() > 0) ? q[0] : 9'h0;
    endfunction

    // compare against the model on every clock while the model is settled
    always begin
        @(posedge clk);
        #3;
        if (cmp_en && !done) begin
            chk("R2", "rd_data", rd_data, m_head() & 9'hFF);
            chk("R3", "rd_bit9", rd_bit9, m_head() >> 8);
            chk("R5", "rx_flag", rx_flag, q.size() > 0);
            chk("R4", "irq", irq, (q.size() > 0) && int_en);
            chk("R6", "overrun", overrun, m_halt);
            chk("R10", "wake_req", wake_req, core_sleep && (q.size() > 0) && int_en);
        end
    end

    task automatic set_ctrl(input logic pe, input logic sm, input logic ms, input logic ce);
        cmp_en = 0;
        @(negedge clk);
        port_en = pe; sync_mode = sm; clk_src_master = ms; cont_rx_en = ce;
        repeat (3) @(negedge clk);
        if (!m_active()) begin m_cnt = 0; m_bits = '0; end
        if (!cont_rx_en) m_halt = 0;
        cmp_en = 1;
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        ser_clk  = 1;
        repeat (4) @(negedge clk);
        ser_clk = 0;
        if (m_active() && !m_halt) begin
            m_bits[m_cnt] = b;
            m_cnt++;
            if (m_cnt == (nine_bit_en ? 9 : 8)) begin
                if (q.size() >= 2) m_halt = 1;
                else q.push_back(nine_bit_en ? m_bits : (m_bits & 9'h0FF));
                m_cnt = 0;
                m_bits = '0;
            end
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic send_word(input logic [8:0] w, input int n);
        cmp_en = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) send_bit(w[i]);
        ser_clk = 1;
        repeat (6) @(negedge clk);
        cmp_en = 1;
    endtask

    task automatic pop_one();
        cmp_en = 0;
        @(negedge clk);
        rd_pop = 1;
        @(negedge clk);
        rd_pop = 0;
        if (!core_sleep && q.size() > 0) void'(q.pop_front());
        cmp_en = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "rx_flag", rx_flag, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "wake_req", wake_req, 0);
        chk("R1", "rd_bit9", rd_bit9, 0);
        cmp_en = 1;

        // R2 basic 8-bit reception, R4 interrupt gating
        set_ctrl(1, 1, 0, 1);
        send_word(9'h0A5, 8);
        chk("R2", "first word", rd_data, 8'hA5);
        chk("R4", "irq masked", irq, 0);
        int_en = 1;
        @(negedge clk);
        chk("R4", "irq enabled", irq, 1);
        pop_one();
        chk("R5", "flag after pop", rx_flag, 0);

        // R3 ninth bit
        nine_bit_en = 1;
        send_word(9'h13C, 9);
        chk("R3", "data low", rd_data, 8'h3C);
        chk("R3", "bit9 set", rd_bit9, 1);
        pop_one();
        send_word(9'h0FF, 9);
        chk("R3", "bit9 clear", rd_bit9, 0);
        chk("R3", "data ff", rd_data, 8'hFF);
        pop_one();
        nine_bit_en = 0;
        send_word(9'h081, 8);
        chk("R3", "bit9 in 8-bit mode", rd_bit9, 0);
        chk("R2", "word 81", rd_data, 8'h81);
        pop_one();

        // R5 ordering and empty pop
        send_word(9'h011, 8);
        send_word(9'h022, 8);
        chk("R5", "oldest first", rd_data, 8'h11);
        pop_one();
        chk("R5", "second", rd_data, 8'h22);
        pop_one();
        pop_one();
        chk("R5", "empty pop", rx_flag, 0);
        chk("R5", "empty data", rd_data, 0);

        // R6 overrun, R7 clearing
        send_word(9'h031, 8);
        send_word(9'h032, 8);
        send_word(9'h033, 8);
        chk("R6", "overrun set", overrun, 1);
        chk("R6", "head kept", rd_data, 8'h31);
        pop_one();
        chk("R6", "second kept", rd_data, 8'h32);
        pop_one();
        send_word(9'h044, 8);
        chk("R6", "blocked", rx_flag, 0);
        chk("R7", "sticky", overrun, 1);
        set_ctrl(0, 1, 0, 1);
        chk("R7", "port_en low keeps", overrun, 1);
        set_ctrl(1, 1, 0, 1);
        set_ctrl(1, 1, 0, 0);
        chk("R7", "cleared", overrun, 0);
        set_ctrl(1, 1, 0, 1);
        send_word(9'h055, 8);
        chk("R7", "resumes", rd_data, 8'h55);
        pop_one();

        // R8 gating terms
        set_ctrl(1, 1, 1, 1);
        send_word(9'h066, 8);
        chk("R8", "master clock", rx_flag, 0);
        set_ctrl(1, 0, 0, 1);
        send_word(9'h066, 8);
        chk("R8", "async mode", rx_flag, 0);
        set_ctrl(0, 1, 0, 1);
        send_word(9'h066, 8);
        chk("R8", "port off", rx_flag, 0);

        // R9 ignored controls
        single_rx_en = 1;
        addr_det_en = 1;
        set_ctrl(1, 1, 0, 0);
        send_word(9'h066, 8);
        chk("R9", "single enable alone", rx_flag, 0);
        set_ctrl(1, 1, 0, 1);
        send_word(9'h077, 8);
        chk("R9", "with addr detect", rd_data, 8'h77);
        pop_one();
        single_rx_en = 0;
        addr_det_en = 0;

        // R11 partial word discard
        send_word(9'h007, 3);
        set_ctrl(1, 1, 0, 0);
        set_ctrl(1, 1, 0, 1);
        send_word(9'h09A, 8);
        chk("R11", "realigned", rd_data, 8'h9A);
        pop_one();

        // R10 sleep
        core_sleep = 1;
        @(negedge clk);
        chk("R10", "no wake when empty", wake_req, 0);
        send_word(9'h0C3, 8);
        chk("R10", "wake", wake_req, 1);
        pop_one();
        chk("R10", "pop refused", rd_data, 8'hC3);
        core_sleep = 0;
        @(negedge clk);
        chk("R10", "wake clears", wake_req, 0);
        pop_one();
        chk("R10", "pop after wake", rx_flag, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule